// File: doc/BRIEF.md
# Charger Configuration Register Slave for a Two-Wire Management Bus

This block is the bus-facing register bank of a battery charger. It listens on a two-wire SMBus-style management bus as a slave only, never starting a transfer, and it holds the words that the rest of the charger uses as settings: an option word, a charge-current word, a charge-voltage word and an input-current-limit word. A host writes a 16-bit word with a Write-Word transfer and reads one back with a Read-Word transfer. Two command codes return fixed identification words.

Both bus lines are open-drain. Each line comes in as a level, and the slave pulls data low through a separate drive-low output. Both inputs pass through a two-stage synchronizer and are edge-detected on the system clock. START and STOP are taken from data edges seen while the clock line is high. An enable input stands for "supply valid and adapter present". While it is low the slave ignores the bus and never pulls the data line.

Input-current writes are range-checked. An out-of-range value clears the word and raises a charge-stop flag. A write to the charge-current or charge-voltage word produces a one-cycle update pulse for the charge loop. If the bus clock is held low for too long, any transfer in progress is abandoned.

Top module: `chg_smbus_regs`

## Requirements
- R1: The slave acknowledges only the 7-bit address 0x09, sent as the address byte 0x12 for a write or 0x13 for a read. For any other address it leaves the data line released in the acknowledge slot, and no word changes.
- R2: A Write-Word transfer writes command code 0x12 (option), 0x14 (charge current), 0x15 (charge voltage) or 0x3F (input current). The sequence is START, address+W, command, low data byte, high data byte, STOP. A Read-Word transfer returns the same word, low byte first, each byte sent MSB first. The sequence is START, address+W, command, repeated START, address+R, low byte with master ACK, high byte with master NACK, STOP.
- R3: Command 0xFE always reads back 0x0040 and command 0xFF always reads back 0x0008. Data written to either code is discarded.
- R4: The input-current word resets to 0x1000 (4096 mA). It keeps only bits [12:7] of an accepted value, so it counts in 128 mA steps.
- R5: A written input-current value below 128 or above 8064 clears the input-current word to 0 and sets the charge-stop flag. A later write in range sets the word and clears the flag.
- R6: The slave does not acknowledge a command code other than 0x12, 0x14, 0x15, 0x3F, 0xFE or 0xFF. It does not acknowledge the data bytes that follow such a code, and no word changes.
- R7: While the bus enable is low, the slave never pulls the data line low and no word changes.
- R8: If the bus clock stays low for more than the timeout count of system clocks, the transfer in progress is abandoned. A write cut short this way changes nothing, and the next transfer works normally.
- R9: Every write to 0x14 or 0x15 produces exactly one update pulse, one system clock wide. Writes to other codes produce none.
- R10: After reset the option word is 0x7902, the charge-current and charge-voltage words are 0, and the charge-stop flag is low.
- R11: For every byte the slave accepts, it pulls the data line low during the ninth bus clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Supply-valid and adapter-present; bus is ignored while low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_drive_low | output | 1 | Pulls the data line low when high |
| opt_word | output | 16 | Option word (command 0x12) |
| ichg_word | output | 16 | Charge-current word (command 0x14) |
| vchg_word | output | 16 | Charge-voltage word (command 0x15) |
| iin_word | output | 16 | Input-current-limit word (command 0x3F) |
| chg_update_pulse | output | 1 | One-cycle pulse on a charge-current or charge-voltage write |
| chg_terminate | output | 1 | Charge-stop flag after an illegal input-current write |

## Verification
Each bus-clock edge takes two synchronizer stages and one register to reach the slave. The data-line drive therefore changes three to four system clocks after a falling bus-clock edge. The bench holds each bus-clock half period for ten system clocks and samples the data line five clocks into the high phase, so the acknowledge and read bits it observes have been stable for several clocks. A written word and its update pulse appear about four clocks after the falling edge that ends the high data byte. The bench checks the words and the pulse count only after the STOP condition, well past that point. The timeout case holds the clock low for two hundred clocks beyond the limit before it resumes.

// File: rtl/chg_smbus_pkg.sv
`timescale 1ns/1ps
package chg_smbus_pkg;

  localparam logic [7:0] CMD_OPT  = 8'h12;
  localparam logic [7:0] CMD_ICHG = 8'h14;
  localparam logic [7:0] CMD_VCHG = 8'h15;
  localparam logic [7:0] CMD_IIN  = 8'h3F;
  localparam logic [7:0] CMD_ID_A = 8'hFE;
  localparam logic [7:0] CMD_ID_B = 8'hFF;

  localparam logic [15:0] ID_A_VAL = 16'h0040;
  localparam logic [15:0] ID_B_VAL = 16'h0008;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_CMD, PH_DLO, PH_DHI, PH_TXLO, PH_TXHI, PH_DONE
  } phase_t;

  function automatic logic cmd_known(input logic [7:0] c);
    return (c == CMD_OPT) || (c == CMD_ICHG) || (c == CMD_VCHG) ||
           (c == CMD_IIN) || (c == CMD_ID_A) || (c == CMD_ID_B);
  endfunction

endpackage

// File: rtl/chg_line_sync.sv
`timescale 1ns/1ps
module chg_line_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= '1;
      else     pipe <= {pipe[STAGES-1:0], raw[g]};
    end
    assign lvl[g]  = pipe[STAGES-1];
    assign rise[g] = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall[g] = ~pipe[STAGES-1] & pipe[STAGES];
  end

endmodule

// File: rtl/chg_scl_watch.sv
`timescale 1ns/1ps
module chg_scl_watch #(
  parameter int TIMEOUT_CYC = 7_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_lvl,
  output logic expired
);

  localparam int CW = $clog2(TIMEOUT_CYC + 2);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || scl_lvl) begin
      low_cnt <= '0;
      expired <= 1'b0;
    end else begin
      if (low_cnt <= LIMIT) low_cnt <= low_cnt + 1'b1;
      expired <= (low_cnt == LIMIT);
    end
  end

endmodule

// File: rtl/chg_smbus_phy.sv
`timescale 1ns/1ps
module chg_smbus_phy
  import chg_smbus_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h09
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_en,
  input  logic        abort,
  input  logic        scl_lvl,
  input  logic        scl_rise,
  input  logic        scl_fall,
  input  logic        sda_lvl,
  input  logic        sda_rise,
  input  logic        sda_fall,
  input  logic [15:0] rdata,
  output logic [7:0]  cmd_q,
  output logic        wr_en,
  output logic [15:0] wr_data,
  output logic        drive
);

  phase_t      phase, nxt_phase;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg, lo_q, tx_q;
  logic        cmd_ok, master_ack;

  wire start_ev = scl_lvl & sda_fall;
  wire stop_ev  = scl_lvl & sda_rise;
  wire tx_phase = (phase == PH_TXLO) || (phase == PH_TXHI);

  always_ff @(posedge clk) begin
    if (rst || !bus_en || abort) begin
      phase      <= PH_IDLE;
      nxt_phase  <= PH_DONE;
      bitcnt     <= '0;
      shreg      <= '0;
      lo_q       <= '0;
      tx_q       <= '0;
      cmd_q      <= '0;
      cmd_ok     <= 1'b0;
      master_ack <= 1'b0;
      wr_en      <= 1'b0;
      wr_data    <= '0;
      drive      <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_ev) begin
        phase  <= PH_ADDR;
        bitcnt <= '0;
        drive  <= 1'b0;
      end else if (stop_ev) begin
        phase  <= PH_IDLE;
        cmd_ok <= 1'b0;
        drive  <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8)  shreg <= {shreg[6:0], sda_lvl};
          if (bitcnt == 4'd8) master_ack <= ~sda_lvl;
          if (bitcnt < 4'd9)  bitcnt <= bitcnt + 1'b1;
        end else if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            nxt_phase <= PH_DONE;
            drive     <= 1'b0;
            case (phase)
              PH_ADDR: begin
                if (shreg[7:1] == SLV_ADDR) begin
                  if (!shreg[0]) begin
                    drive <= 1'b1; nxt_phase <= PH_CMD;
                  end else if (cmd_ok) begin
                    drive <= 1'b1; nxt_phase <= PH_TXLO;
                  end
                end
              end
              PH_CMD: begin
                if (cmd_known(shreg)) begin
                  drive     <= 1'b1;
                  cmd_q     <= shreg;
                  cmd_ok    <= 1'b1;
                  nxt_phase <= PH_DLO;
                end
              end
              PH_DLO: begin
                drive     <= 1'b1;
                lo_q      <= shreg;
                nxt_phase <= PH_DHI;
              end
              PH_DHI: begin
                drive   <= 1'b1;
                wr_en   <= 1'b1;
                wr_data <= {shreg, lo_q};
              end
              default: ;
            endcase
          end else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            drive  <= 1'b0;
            case (phase)
              PH_TXLO: begin
                if (master_ack) begin
                  phase <= PH_TXHI;
                  tx_q  <= rdata[15:8];
                  drive <= ~rdata[15];
                end else begin
                  phase <= PH_DONE;
                end
              end
              PH_TXHI: phase <= PH_DONE;
              PH_ADDR, PH_CMD, PH_DLO, PH_DHI: begin
                phase <= nxt_phase;
                if (nxt_phase == PH_TXLO) begin
                  tx_q  <= rdata[7:0];
                  drive <= ~rdata[7];
                end
              end
              default: ;
            endcase
          end else if (tx_phase && bitcnt != 4'd0) begin
            drive <= ~tx_q[6];
            tx_q  <= {tx_q[6:0], 1'b0};
          end
        end
      end
    end
  end

endmodule

// File: rtl/chg_reg_bank.sv
`timescale 1ns/1ps
module chg_reg_bank
  import chg_smbus_pkg::*;
#(
  parameter logic [15:0] OPT_RST  = 16'h7902,
  parameter logic [15:0] IIN_RST  = 16'h1000,
  parameter logic [15:0] IIN_MIN  = 16'd128,
  parameter logic [15:0] IIN_MAX  = 16'd8064,
  parameter logic [15:0] IIN_MASK = 16'h1F80
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [7:0]  cmd,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic [15:0] opt_word,
  output logic [15:0] ichg_word,
  output logic [15:0] vchg_word,
  output logic [15:0] iin_word,
  output logic        update_pulse,
  output logic        terminate
);

  wire iin_legal = (wr_data >= IIN_MIN) && (wr_data <= IIN_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      opt_word     <= OPT_RST;
      ichg_word    <= '0;
      vchg_word    <= '0;
      iin_word     <= IIN_RST;
      update_pulse <= 1'b0;
      terminate    <= 1'b0;
    end else begin
      update_pulse <= 1'b0;
      if (wr_en) begin
        case (cmd)
          CMD_OPT:  opt_word <= wr_data;
          CMD_ICHG: begin ichg_word <= wr_data; update_pulse <= 1'b1; end
          CMD_VCHG: begin vchg_word <= wr_data; update_pulse <= 1'b1; end
          CMD_IIN: begin
            if (iin_legal) begin
              iin_word  <= wr_data & IIN_MASK;
              terminate <= 1'b0;
            end else begin
              iin_word  <= '0;
              terminate <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (cmd)
      CMD_OPT:  rd_data = opt_word;
      CMD_ICHG: rd_data = ichg_word;
      CMD_VCHG: rd_data = vchg_word;
      CMD_IIN:  rd_data = iin_word;
      CMD_ID_A: rd_data = ID_A_VAL;
      CMD_ID_B: rd_data = ID_B_VAL;
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/chg_smbus_regs.sv
`timescale 1ns/1ps
module chg_smbus_regs #(
  parameter logic [6:0]  SLV_ADDR    = 7'h09,
  parameter int          TIMEOUT_CYC = 7_500_000,
  parameter logic [15:0] OPT_RST     = 16'h7902,
  parameter logic [15:0] IIN_RST     = 16'h1000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_en,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_drive_low,
  output logic [15:0] opt_word,
  output logic [15:0] ichg_word,
  output logic [15:0] vchg_word,
  output logic [15:0] iin_word,
  output logic        chg_update_pulse,
  output logic        chg_terminate
);

  logic [1:0]  lvl, rise, fall;
  logic        expired, wr_en;
  logic [7:0]  cmd_q;
  logic [15:0] wr_data, rd_data;

  chg_line_sync #(.N(2), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .raw({sda_i, scl_i}),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  chg_scl_watch #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_watch (
    .clk(clk), .rst(rst), .scl_lvl(lvl[0]), .expired(expired)
  );

  chg_smbus_phy #(.SLV_ADDR(SLV_ADDR)) u_phy (
    .clk(clk), .rst(rst), .bus_en(bus_en), .abort(expired),
    .scl_lvl(lvl[0]), .scl_rise(rise[0]), .scl_fall(fall[0]),
    .sda_lvl(lvl[1]), .sda_rise(rise[1]), .sda_fall(fall[1]),
    .rdata(rd_data), .cmd_q(cmd_q), .wr_en(wr_en), .wr_data(wr_data),
    .drive(sda_drive_low)
  );

  chg_reg_bank #(.OPT_RST(OPT_RST), .IIN_RST(IIN_RST)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .cmd(cmd_q), .wr_data(wr_data),
    .rd_data(rd_data), .opt_word(opt_word), .ichg_word(ichg_word),
    .vchg_word(vchg_word), .iin_word(iin_word),
    .update_pulse(chg_update_pulse), .terminate(chg_terminate)
  );

endmodule

// File: rtl/chg_smbus_regs_chk.sv
`timescale 1ns/1ps
module chg_smbus_regs_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_en,
  input logic        sda_drive_low,
  input logic [15:0] iin_word,
  input logic        chg_update_pulse,
  input logic        chg_terminate
);

  a_r9_pulse_single: assert property (@(posedge clk) disable iff (rst)
    chg_update_pulse |=> !chg_update_pulse);

  a_r7_quiet_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !bus_en |=> !sda_drive_low);

  a_r5_term_clears_iin: assert property (@(posedge clk) disable iff (rst)
    chg_terminate |-> (iin_word == 16'h0000));

  a_r4_iin_step: assert property (@(posedge clk) disable iff (rst)
    (iin_word[6:0] == 7'd0) && (iin_word[15:13] == 3'd0));

  a_r5_term_rise_clears: assert property (@(posedge clk) disable iff (rst)
    $rose(chg_terminate) |-> (iin_word == 16'h0000));

endmodule

bind chg_smbus_regs chg_smbus_regs_chk u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .sda_drive_low(sda_drive_low),
  .iin_word(iin_word), .chg_update_pulse(chg_update_pulse),
  .chg_terminate(chg_terminate)
);

// File: tb/chg_smbus_regs_bench.sv
`timescale 1ns/1ps
module chg_smbus_regs_bench;

  localparam int TO_CYC = 2000;
  localparam logic [6:0] ADR = 7'h09;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_en = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_drive_low, chg_update_pulse, chg_terminate;
  logic [15:0] opt_word, ichg_word, vchg_word, iin_word;
  wire sda_line = sda_m & ~sda_drive_low;

  int vectors = 0;
  int errors  = 0;
  int pulse_cnt = 0;
  int run = 0;
  int maxrun = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  chg_smbus_regs #(.TIMEOUT_CYC(TO_CYC)) u_chg_smbus_regs (
    .clk(clk), .rst(rst), .bus_en(bus_en), .scl_i(scl_m), .sda_i(sda_line),
    .sda_drive_low(sda_drive_low), .opt_word(opt_word), .ichg_word(ichg_word),
    .vchg_word(vchg_word), .iin_word(iin_word),
    .chg_update_pulse(chg_update_pulse), .chg_terminate(chg_terminate)
  );

  always @(posedge clk) begin
    if (chg_update_pulse) begin
      pulse_cnt++; run++;
      if (run > maxrun) maxrun = run;
    end else run = 0;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b, output logic s);
    wait_clk(5); sda_m = b;
    wait_clk(5); scl_m = 1'b1;
    wait_clk(5); s = sda_line;
    wait_clk(5); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(8);
    scl_m = 1'b1; wait_clk(10);
    sda_m = 1'b0; wait_clk(10);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wait_clk(5); sda_m = 1'b0;
    wait_clk(5); scl_m = 1'b1;
    wait_clk(10); sda_m = 1'b1;
    wait_clk(20);
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); d[i] = s; end
    clk_bit(~give_ack, s);
  endtask

  task automatic smb_write(input logic [6:0] a, input logic [7:0] c,
                           input logic [15:0] d, output logic [3:0] acks);
    bus_start();
    write_byte({a, 1'b0}, acks[0]);
    write_byte(c, acks[1]);
    write_byte(d[7:0], acks[2]);
    write_byte(d[15:8], acks[3]);
    bus_stop();
  endtask

  task automatic smb_read(input logic [7:0] c, output logic [15:0] d, output logic [2:0] acks);
    bus_start();
    write_byte({ADR, 1'b0}, acks[0]);
    write_byte(c, acks[1]);
    bus_start();
    write_byte({ADR, 1'b1}, acks[2]);
    read_byte(1'b1, d[7:0]);
    read_byte(1'b0, d[15:8]);
    bus_stop();
  endtask

  task automatic t_reset();
    check("R10 option reset", opt_word, 16'h7902);
    check("R10 charge current reset", ichg_word, 16'h0000);
    check("R10 charge voltage reset", vchg_word, 16'h0000);
    check("R10 terminate reset", {15'd0, chg_terminate}, 16'h0000);
    check("R4 input current reset", iin_word, 16'h1000);
    check("R7 no drive after reset", {15'd0, sda_drive_low}, 16'h0000);
  endtask

  task automatic t_write_read();
    logic [3:0] wa; logic [2:0] ra; logic [15:0] d;
    smb_write(ADR, 8'h15, 16'h3130, wa);
    check("R11 acks on write", {12'd0, wa}, 16'h000F);
    check("R2 voltage word", vchg_word, 16'h3130);
    smb_read(8'h15, d, ra);
    check("R2 voltage readback", d, 16'h3130);
    check("R11 acks on read", {13'd0, ra}, 16'h0007);
    smb_write(ADR, 8'h12, 16'hABCD, wa);
    check("R2 option word", opt_word, 16'hABCD);
    smb_read(8'h12, d, ra);
    check("R2 option readback", d, 16'hABCD);
  endtask

  task automatic t_ids();
    logic [3:0] wa; logic [2:0] ra; logic [15:0] d;
    smb_read(8'hFE, d, ra);
    check("R3 id 0xFE", d, 16'h0040);
    smb_read(8'hFF, d, ra);
    check("R3 id 0xFF", d, 16'h0008);
    smb_write(ADR, 8'hFE, 16'h1234, wa);
    smb_read(8'hFE, d, ra);
    check("R3 id 0xFE after write", d, 16'h0040);
  endtask

  task automatic t_addr();
    logic [3:0] wa;
    smb_write(7'h0A, 8'h14, 16'h0555, wa);
    check("R1 foreign address nack", {15'd0, wa[0]}, 16'h0000);
    check("R1 word unchanged", ichg_word, 16'h0000);
  endtask

  task automatic t_badcmd();
    logic [3:0] wa;
    smb_write(ADR, 8'h20, 16'h0777, wa);
    check("R6 addr ack", {15'd0, wa[0]}, 16'h0001);
    check("R6 bad command nack", {13'd0, wa[3:1]}, 16'h0000);
    check("R6 words unchanged", ichg_word | vchg_word, 16'h3130);
  endtask

  task automatic t_iin();
    logic [3:0] wa; logic [2:0] ra; logic [15:0] d;
    smb_write(ADR, 8'h3F, 16'd200, wa);
    check("R4 masked to 128 mA step", iin_word, 16'h0080);
    check("R5 flag low on legal", {15'd0, chg_terminate}, 16'h0000);
    smb_write(ADR, 8'h3F, 16'd8065, wa);
    check("R5 above max clears", iin_word, 16'h0000);
    check("R5 flag set above max", {15'd0, chg_terminate}, 16'h0001);
    smb_write(ADR, 8'h3F, 16'd127, wa);
    check("R5 below min clears", iin_word, 16'h0000);
    check("R5 flag held below min", {15'd0, chg_terminate}, 16'h0001);
    smb_write(ADR, 8'h3F, 16'd8064, wa);
    check("R5 max legal", iin_word, 16'h1F80);
    check("R5 flag cleared", {15'd0, chg_terminate}, 16'h0000);
    smb_read(8'h3F, d, ra);
    check("R4 readback", d, 16'h1F80);
  endtask

  task automatic t_pulse();
    logic [3:0] wa; int p0;
    p0 = pulse_cnt;
    smb_write(ADR, 8'h14, 16'h0B80, wa);
    check("R9 pulse on charge current", 16'(pulse_cnt - p0), 16'd1);
    check("R2 charge current word", ichg_word, 16'h0B80);
    p0 = pulse_cnt;
    smb_write(ADR, 8'h3F, 16'd1024, wa);
    smb_write(ADR, 8'h12, 16'h0001, wa);
    check("R9 no pulse on other codes", 16'(pulse_cnt - p0), 16'd0);
    check("R9 pulse width", 16'(maxrun), 16'd1);
  endtask

  task automatic t_disable();
    logic [3:0] wa;
    bus_en = 1'b0;
    smb_write(ADR, 8'h14, 16'h0100, wa);
    check("R7 no ack while disabled", {12'd0, wa}, 16'h0000);
    check("R7 word unchanged", ichg_word, 16'h0B80);
    bus_en = 1'b1;
    wait_clk(10);
  endtask

  task automatic t_timeout();
    logic a; logic [3:0] wa;
    bus_start();
    write_byte({ADR, 1'b0}, a);
    write_byte(8'h14, a);
    write_byte(8'h22, a);
    wait_clk(TO_CYC + 200);
    write_byte(8'h11, a);
    check("R8 no ack after timeout", {15'd0, a}, 16'h0000);
    bus_stop();
    check("R8 aborted write discarded", ichg_word, 16'h0B80);
    smb_write(ADR, 8'h14, 16'h0200, wa);
    check("R8 next transfer ok", ichg_word, 16'h0200);
  endtask

  initial begin
    wait_clk(10);
    rst = 1'b0;
    wait_clk(10);
    t_reset();
    t_write_read();
    t_ids();
    t_addr();
    t_badcmd();
    t_iin();
    t_pulse();
    t_disable();
    t_timeout();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule